// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block takes a 64-bit interrupt command word written by one of up to eight local interrupt units and works out which units should receive the interrupt. Every unit supplies its own physical ID, an 8-bit logical address, a destination-format nibble and a present flag. From these the block builds a target mask for the command. In directed modes the mask holds every matching unit. In lowest-priority mode exactly one unit is chosen from the matching set, by a rotating pointer that is kept separately for each vector.

A command is accepted on a one-cycle write strobe. One clock later the block issues a one-cycle send strobe. The strobe carries the target mask together with the vector, delivery mode, level and trigger bits taken from the command. The block also returns the stored command word with its delivery-status bit forced to zero, because dispatch is immediate and the command never waits.

Top module: `ipi_dest_match`

## Requirements
- R1: Exactly one cycle after `cmd_wr`, `send_vld` pulses high for one cycle. In that cycle `send_vector`, `send_mode`, `send_level` and `send_trig` equal word bits 7:0, 10:8, 14 and 15 of the written command.
- R2: `cmd_rb` holds the last written command word with bit 12 forced to 0. All other bits are returned unchanged.
- R3: The shorthand field is word bits 19:18. Value 1 targets only unit `src_unit`, value 2 targets every present unit, and value 3 targets every present unit except `src_unit`.
- R4: When the shorthand is 0 and word bit 11 is 0 (physical), a unit matches if its `unit_id` equals the destination byte, which is word bits 63:56.
- R5: When the shorthand is 0, bit 11 is 1 (logical) and the unit's format nibble is 4'hF (flat), the unit matches if its logical address ANDed with the destination byte is nonzero.
- R6: When the shorthand is 0, bit 11 is 1 and the unit's format nibble is not 4'hF (cluster), the unit matches only if two conditions hold. Logical address bits 3:0 must equal destination bits 3:0. Logical address bits 7:4 and destination bits 7:4 must also have a common set bit.
- R7: A unit whose `unit_present` bit is 0 never appears in `send_mask`. In lowest-priority mode the scan passes over such a unit.
- R8: Delivery mode 1 (lowest priority) with logical destination selects exactly one matching unit. The scan begins at the unit after the vector's stored pointer and climbs, wrapping from unit 7 to unit 0. The pointer then records the chosen unit. After reset the first scan for any vector begins at unit 0.
- R9: Lowest-priority delivery with physical destination, or with no matching unit, produces an empty mask. In that case the vector's pointer keeps its value.
- R10: Lowest-priority delivery with no shorthand, logical mode and destination 8'hFF, while any present unit has cluster format, pulses `lp_err` alongside the send strobe. The mask is empty and the pointer is unchanged. No other command raises `lp_err`.
- R11: While reset is held and right after it, `send_vld`, `send_mask`, `lp_err` and `cmd_rb` are all zero. Outside the send cycle `send_mask` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 64 | Interrupt command word |
| src_unit | input | 3 | Index of the unit issuing the command |
| unit_present | input | 8 | Per-unit present flag |
| unit_id | input | 64 | Per-unit physical ID, 8 bits each, unit 0 lowest |
| unit_ldr | input | 64 | Per-unit logical address, 8 bits each |
| unit_dfmt | input | 32 | Per-unit destination format nibble (4'hF = flat) |
| send_vld | output | 1 | Send strobe, one cycle after the write |
| send_mask | output | 8 | Target mask, bit i for unit i |
| send_vector | output | 8 | Vector of the dispatched interrupt |
| send_mode | output | 3 | Delivery mode of the dispatched interrupt |
| send_level | output | 1 | Level bit of the command |
| send_trig | output | 1 | Trigger-mode bit of the command |
| lp_err | output | 1 | Dropped lowest-priority cluster broadcast |
| cmd_rb | output | 64 | Command readback, bit 12 cleared |

## Verification
Most internal state here is the table of per-vector rotation pointers. A corrupted or wrongly updated pointer does not show up on the command that causes it. It appears only on the next lowest-priority command for the same vector, as a grant to the wrong unit, as a repeat of the same unit, or as a scan that lands on an absent unit. For this reason the tests interleave vectors, insert commands that must leave a pointer untouched, and check the grant that follows each one. A decode fault shows up in the very next send cycle as a wrong mask bit or field.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int DEST_W = 8;
    localparam int VEC_W  = 8;
    localparam int FMT_W  = 4;
    localparam int DS_BIT = 12;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        shorthand_e        sh;
        logic              trig;
        logic              lvl;
        logic              logical;
        dmode_e            mode;
        logic [VEC_W-1:0]  vec;
    } ipi_cmd_t;

    function automatic ipi_cmd_t decode_cmd(input logic [63:0] w);
        ipi_cmd_t c;
        c.dest    = w[63:56];
        c.sh      = shorthand_e'(w[19:18]);
        c.trig    = w[15];
        c.lvl     = w[14];
        c.logical = w[11];
        c.mode    = dmode_e'(w[10:8]);
        c.vec     = w[7:0];
        return c;
    endfunction

    function automatic logic [63:0] readback_word(input logic [63:0] w);
        logic [63:0] r;
        r         = w;
        r[DS_BIT] = 1'b0;
        return r;
    endfunction

    function automatic logic is_flat(input logic [FMT_W-1:0] f);
        return f == {FMT_W{1'b1}};
    endfunction

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
    import ipi_pkg::*;
#(
    parameter int UNIT_IDX = 0,
    parameter int UW       = 3
) (
    input  ipi_cmd_t           cmd,
    input  logic [UW-1:0]      src,
    input  logic [DEST_W-1:0]  phys_id,
    input  logic [DEST_W-1:0]  log_addr,
    input  logic [FMT_W-1:0]   dfmt,
    input  logic               present,
    output logic               hit
);
    localparam logic [UW-1:0] MY_IDX = UW'(UNIT_IDX);

    logic raw;
    logic flat_hit;
    logic clus_hit;

    always_comb begin
        flat_hit = |(log_addr & cmd.dest);
        clus_hit = (log_addr[3:0] == cmd.dest[3:0]) &&
                   (|(log_addr[7:4] & cmd.dest[7:4]));
        unique case (cmd.sh)
            SH_NONE: begin
                if (!cmd.logical)
                    raw = (phys_id == cmd.dest);
                else if (is_flat(dfmt))
                    raw = flat_hit;
                else
                    raw = clus_hit;
            end
            SH_SELF:   raw = (src == MY_IDX);
            SH_ALL:    raw = 1'b1;
            SH_OTHERS: raw = (src != MY_IDX);
            default:   raw = 1'b0;
        endcase
        hit = present && raw;
    end

endmodule

// File: rtl/ipi_lp_arbiter.sv
module ipi_lp_arbiter
    import ipi_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int NUM_VEC   = 256
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  logic [$clog2(NUM_VEC)-1:0]   vec,
    input  logic [NUM_UNITS-1:0]         cand,
    output logic [NUM_UNITS-1:0]         grant,
    output logic                         found
);
    localparam int UW = $clog2(NUM_UNITS);
    localparam logic [UW-1:0] PTR_INIT = UW'(NUM_UNITS - 1);

    logic [UW-1:0] ptr_q [NUM_VEC];
    logic [UW-1:0] base;
    logic [UW-1:0] pick;

    always_comb begin
        base  = ptr_q[vec];
        grant = '0;
        found = 1'b0;
        pick  = base;
        for (int i = 1; i <= NUM_UNITS; i++) begin
            int idx;
            idx = (int'(base) + i) % NUM_UNITS;
            if (!found && cand[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
                pick       = UW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int v = 0; v < NUM_VEC; v++)
                ptr_q[v] <= PTR_INIT;
        end else if (commit && found) begin
            ptr_q[vec] <= pick;
        end
    end

endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import ipi_pkg::*;
#(
    parameter int NUM_UNITS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_wr,
    input  logic [63:0]                   cmd_word,
    input  logic [$clog2(NUM_UNITS)-1:0]  src_unit,
    input  logic [NUM_UNITS-1:0]          unit_present,
    input  logic [NUM_UNITS*8-1:0]        unit_id,
    input  logic [NUM_UNITS*8-1:0]        unit_ldr,
    input  logic [NUM_UNITS*4-1:0]        unit_dfmt,
    output logic                          send_vld,
    output logic [NUM_UNITS-1:0]          send_mask,
    output logic [7:0]                    send_vector,
    output logic [2:0]                    send_mode,
    output logic                          send_level,
    output logic                          send_trig,
    output logic                          lp_err,
    output logic [63:0]                   cmd_rb
);
    localparam int UW      = $clog2(NUM_UNITS);
    localparam int NUM_VEC = 1 << VEC_W;

    ipi_cmd_t             cmd;
    logic [NUM_UNITS-1:0] hits;
    logic [NUM_UNITS-1:0] clus_units;
    logic [NUM_UNITS-1:0] grant;
    logic                 found;
    logic                 is_lp;
    logic                 bcast_bad;
    logic                 lp_ok;
    logic [NUM_UNITS-1:0] mask_d;

    assign cmd = decode_cmd(cmd_word);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        ipi_unit_match #(.UNIT_IDX(u), .UW(UW)) u_match (
            .cmd      (cmd),
            .src      (src_unit),
            .phys_id  (unit_id[u*DEST_W +: DEST_W]),
            .log_addr (unit_ldr[u*DEST_W +: DEST_W]),
            .dfmt     (unit_dfmt[u*FMT_W +: FMT_W]),
            .present  (unit_present[u]),
            .hit      (hits[u])
        );
        assign clus_units[u] = unit_present[u] &&
                               !is_flat(unit_dfmt[u*FMT_W +: FMT_W]);
    end

    always_comb begin
        is_lp     = (cmd.mode == DM_LOWPRI);
        bcast_bad = is_lp && (cmd.sh == SH_NONE) && cmd.logical &&
                    (cmd.dest == {DEST_W{1'b1}}) && (|clus_units);
        lp_ok     = is_lp && cmd.logical && !bcast_bad;
        if (!is_lp)
            mask_d = hits;
        else if (lp_ok)
            mask_d = grant;
        else
            mask_d = '0;
    end

    ipi_lp_arbiter #(.NUM_UNITS(NUM_UNITS), .NUM_VEC(NUM_VEC)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .commit (cmd_wr && lp_ok),
        .vec    (cmd.vec),
        .cand   (lp_ok ? hits : '0),
        .grant  (grant),
        .found  (found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            send_vld    <= 1'b0;
            send_mask   <= '0;
            send_vector <= '0;
            send_mode   <= '0;
            send_level  <= 1'b0;
            send_trig   <= 1'b0;
            lp_err      <= 1'b0;
            cmd_rb      <= '0;
        end else begin
            send_vld  <= cmd_wr;
            send_mask <= cmd_wr ? mask_d : '0;
            lp_err    <= cmd_wr && bcast_bad;
            if (cmd_wr) begin
                send_vector <= cmd.vec;
                send_mode   <= cmd.mode;
                send_level  <= cmd.lvl;
                send_trig   <= cmd.trig;
                cmd_rb      <= readback_word(cmd_word);
            end
        end
    end

endmodule

// File: rtl/ipi_dest_match_chk.sv
module ipi_dest_match_chk #(
    parameter int NUM_UNITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_wr,
    input logic [63:0]          cmd_word,
    input logic [NUM_UNITS-1:0] unit_present,
    input logic                 send_vld,
    input logic [NUM_UNITS-1:0] send_mask,
    input logic [7:0]           send_vector,
    input logic [2:0]           send_mode,
    input logic                 lp_err,
    input logic [63:0]          cmd_rb
);

    assert_vld_follows_wr_R1: assert property (@(posedge clk) disable iff (rst)
        send_vld |-> $past(cmd_wr));

    assert_vector_carried_R1: assert property (@(posedge clk) disable iff (rst)
        send_vld |-> (send_vector == $past(cmd_word[7:0])));

    assert_status_bit_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !cmd_rb[12]);

    assert_no_absent_target_R7: assert property (@(posedge clk) disable iff (rst)
        send_vld |-> ((send_mask & ~$past(unit_present)) == '0));

    assert_lowpri_single_R8: assert property (@(posedge clk) disable iff (rst)
        (send_vld && send_mode == 3'd1) |-> $onehot0(send_mask));

    assert_err_empty_mask_R10: assert property (@(posedge clk) disable iff (rst)
        lp_err |-> (send_vld && send_mask == '0));

    assert_idle_mask_R11: assert property (@(posedge clk) disable iff (rst)
        !send_vld |-> (send_mask == '0 && !lp_err));

endmodule

bind ipi_dest_match ipi_dest_match_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_wr       (cmd_wr),
    .cmd_word     (cmd_word),
    .unit_present (unit_present),
    .send_vld     (send_vld),
    .send_mask    (send_mask),
    .send_vector  (send_vector),
    .send_mode    (send_mode),
    .lp_err       (lp_err),
    .cmd_rb       (cmd_rb)
);

// File: tb/ipi_dest_match_test.sv
module ipi_dest_match_test;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_wr = 1'b0;
    logic [63:0]   cmd_word = '0;
    logic [2:0]    src_unit = '0;
    logic [N-1:0]  unit_present = '0;
    logic [N*8-1:0] unit_id = '0;
    logic [N*8-1:0] unit_ldr = '0;
    logic [N*4-1:0] unit_dfmt = '0;
    logic          send_vld;
    logic [N-1:0]  send_mask;
    logic [7:0]    send_vector;
    logic [2:0]    send_mode;
    logic          send_level;
    logic          send_trig;
    logic          lp_err;
    logic [63:0]   cmd_rb;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic          c_vld;
    logic [N-1:0]  c_mask;
    logic [7:0]    c_vec;
    logic [2:0]    c_mode;
    logic          c_lvl;
    logic          c_trig;
    logic          c_err;
    logic [63:0]   c_rb;

    always #4 clk = ~clk;

    ipi_dest_match #(.NUM_UNITS(N)) uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .src_unit(src_unit), .unit_present(unit_present), .unit_id(unit_id),
        .unit_ldr(unit_ldr), .unit_dfmt(unit_dfmt), .send_vld(send_vld),
        .send_mask(send_mask), .send_vector(send_vector), .send_mode(send_mode),
        .send_level(send_level), .send_trig(send_trig), .lp_err(lp_err),
        .cmd_rb(cmd_rb)
    );

    function automatic logic [63:0] mk(input logic [7:0] dest, input logic [1:0] sh,
                                       input logic trig, input logic lvl,
                                       input logic logical, input logic [2:0] mode,
                                       input logic [7:0] vec);
        return {dest, 24'h0, 12'h0, sh, 2'b00, trig, lvl, 1'b0, 1'b0,
                logical, mode, vec};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] w, input logic [2:0] src);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = w;
        src_unit = src;
        @(posedge clk);
        #1;
        c_vld = send_vld; c_mask = send_mask; c_vec = send_vector;
        c_mode = send_mode; c_lvl = send_level; c_trig = send_trig;
        c_err = lp_err; c_rb = cmd_rb;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic send_mask_chk(input string req, input logic [63:0] w,
                                 input logic [2:0] src, input logic [N-1:0] exp);
        send(w, src);
        chk(req, "mask", 64'(c_mask), 64'(exp));
    endtask

    task automatic set_flat();
        for (int i = 0; i < N; i++) begin
            unit_ldr[i*8 +: 8]  = 8'(1 << i);
            unit_dfmt[i*4 +: 4] = 4'hF;
        end
    endtask

    task automatic set_cluster();
        for (int i = 0; i < N; i++) begin
            unit_ldr[i*8 +: 8]  = {4'(1 << (i % 4)), 4'(i / 4 + 1)};
            unit_dfmt[i*4 +: 4] = 4'h0;
        end
    endtask

    task automatic t_reset();
        chk("R11", "vld", 64'(send_vld), 0);
        chk("R11", "mask", 64'(send_mask), 0);
        chk("R11", "err", 64'(lp_err), 0);
        chk("R11", "rb", cmd_rb, 0);
    endtask

    task automatic t_fields();
        logic [63:0] w;
        w = mk(8'h13, 2'd0, 1'b1, 1'b1, 1'b0, 3'd0, 8'h41) | (64'd1 << 12);
        send(w, 3'd0);
        chk("R1", "vld", 64'(c_vld), 1);
        chk("R1", "vector", 64'(c_vec), 64'h41);
        chk("R1", "mode", 64'(c_mode), 0);
        chk("R1", "level", 64'(c_lvl), 1);
        chk("R1", "trig", 64'(c_trig), 1);
        chk("R4", "mask phys", 64'(c_mask), 64'h08);
        chk("R2", "readback", c_rb, w & ~(64'd1 << 12));
        @(posedge clk); #1;
        chk("R1", "vld one cycle", 64'(send_vld), 0);
        chk("R11", "idle mask", 64'(send_mask), 0);
        send(mk(8'h10, 2'd0, 1'b0, 1'b0, 1'b0, 3'd4, 8'h02), 3'd1);
        chk("R1", "mode nmi", 64'(c_mode), 4);
        chk("R1", "level0", 64'(c_lvl), 0);
        chk("R4", "mask unit0", 64'(c_mask), 64'h01);
    endtask

    task automatic t_physical_absent();
        send_mask_chk("R7", mk(8'h16, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h30), 3'd0, 8'h00);
        send_mask_chk("R4", mk(8'h55, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h30), 3'd0, 8'h00);
    endtask

    task automatic t_flat();
        set_flat();
        send_mask_chk("R5", mk(8'h45, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h31), 3'd0, 8'h05);
        send_mask_chk("R5", mk(8'h80, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h31), 3'd0, 8'h80);
    endtask

    task automatic t_shorthand();
        send_mask_chk("R3", mk(8'h00, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h40), 3'd3, 8'h08);
        send_mask_chk("R3", mk(8'h00, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 8'h40), 3'd3, 8'hBF);
        send_mask_chk("R3", mk(8'h00, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0, 8'h40), 3'd0, 8'hBE);
    endtask

    task automatic t_cluster();
        set_cluster();
        send_mask_chk("R6", mk(8'h32, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h42), 3'd0, 8'h30);
        send_mask_chk("R6", mk(8'h52, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h42), 3'd0, 8'h10);
        send_mask_chk("R6", mk(8'hF1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h42), 3'd0, 8'h0F);
        send(mk(8'hFF, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h42), 3'd0);
        chk("R10", "fixed no err", 64'(c_err), 0);
        send(mk(8'hFF, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h50), 3'd0);
        chk("R10", "lp bcast err", 64'(c_err), 1);
        chk("R10", "lp bcast mask", 64'(c_mask), 0);
        set_flat();
    endtask

    task automatic t_lowpri();
        logic [63:0] all50, all51;
        all50 = mk(8'hFF, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h50);
        all51 = mk(8'hFF, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h51);
        send_mask_chk("R8", all50, 3'd0, 8'h01);
        chk("R10", "flat no err", 64'(c_err), 0);
        send_mask_chk("R8", all50, 3'd0, 8'h02);
        send_mask_chk("R8", all51, 3'd0, 8'h01);
        send_mask_chk("R8", all50, 3'd0, 8'h04);
        send_mask_chk("R9", mk(8'h10, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 8'h50), 3'd0, 8'h00);
        send_mask_chk("R9", all50, 3'd0, 8'h08);
        send_mask_chk("R9", mk(8'h40, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h50), 3'd0, 8'h00);
        send_mask_chk("R9", all50, 3'd0, 8'h10);
        send_mask_chk("R8", mk(8'h81, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h50), 3'd0, 8'h80);
        send_mask_chk("R8", mk(8'h81, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h50), 3'd0, 8'h01);
        send_mask_chk("R7", mk(8'h60, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h52), 3'd0, 8'h20);
        send_mask_chk("R7", mk(8'h60, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h52), 3'd0, 8'h20);
        send_mask_chk("R8", mk(8'h00, 2'd3, 1'b0, 1'b0, 1'b1, 3'd1, 8'h53), 3'd0, 8'h02);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        unit_present = 8'hBF;
        for (int i = 0; i < N; i++)
            unit_id[i*8 +: 8] = 8'(8'h10 + i);
        set_flat();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_fields();
        t_physical_absent();
        t_flat();
        t_shorthand();
        t_cluster();
        t_lowpri();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule